// File: doc/BRIEF.md
# Overlay Channel Alpha Compositor

This block is one pixel stage of a display compositor. It places a single input layer inside a rectangular window on the output raster. Inside that window it blends the layer over the background pixel it receives. Background pixels arrive in raster order, together with their x/y coordinates. A matching layer pixel, with its own valid flag and per-pixel alpha, arrives alongside each background pixel.

Configuration is held on static inputs:

- two window corners;
- a channel enable;
- a source select, which must equal this channel's index plus one for the layer to apply;
- an 8-bit global alpha;
- a flag saying whether the layer format carries per-pixel alpha.

The blend weight is chosen from the flag and the global alpha. Pixels that are not covered by an active layer leave the block unchanged, two cycles after they enter.

Top module: `ovl_blend`

## Requirements
- R1: While reset is asserted and on the first cycles after it is released, `out_valid` is low.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock cycles. `out_rgb` in that cycle belongs to that input pixel.
- R3: The window is inclusive of both corners. `win_tl` gives the top-left corner and `win_br` gives the bottom-right corner. Each corner word holds X in bits 31:16 and Y in bits 15:0. A pixel whose x or y lies outside the window leaves with its background value unchanged.
- R4: With `ch_en` low, every pixel leaves with its background value unchanged.
- R5: The layer applies only when `ch_sel` equals CHAN_IDX+1. Any other value passes the background through unchanged.
- R6: A pixel arriving with `lay_valid` low passes its background through unchanged.
- R7: With `lay_has_alpha` low, the weight is `glb_alpha`. A value of 255 is fully opaque, so the output is the layer pixel. A value of 0 gives the background.
- R8: With `lay_has_alpha` high and `glb_alpha` equal to 255, the weight is the per-pixel `lay_alpha`.
- R9: With `lay_has_alpha` high and `glb_alpha` below 255, the weight is (lay_alpha*glb_alpha+127)/255, using integer division.
- R10: Each 8-bit component is computed as (a*layer+(255-a)*background+127)/255, where a is the weight. Red is in bits 23:16, green in bits 15:8 and blue in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | 1 | Channel enable |
| ch_sel | input | SELW | Source select; active value CHAN_IDX+1 |
| lay_has_alpha | input | 1 | Layer format has per-pixel alpha |
| glb_alpha | input | CW | Global alpha, all ones is opaque |
| win_tl | input | 32 | Top-left corner, X[31:16] Y[15:0] |
| win_br | input | 32 | Inclusive bottom-right corner, X[31:16] Y[15:0] |
| in_valid | input | 1 | Background pixel valid |
| in_x | input | 16 | Pixel column |
| in_y | input | 16 | Pixel row |
| in_bg | input | 3*CW | Background RGB |
| lay_valid | input | 1 | Layer pixel valid |
| lay_rgb | input | 3*CW | Layer RGB |
| lay_alpha | input | CW | Layer per-pixel alpha |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 3*CW | Blended RGB |

## Verification
The assertions assume that the configuration inputs stay stable while a pixel is in flight. They also assume that `win_tl` does not lie to the right of, or below, `win_br`. The bench changes configuration only between frames, after two idle cycles that flush the pipeline, and it always programs ordered corners. The checker compares outputs with inputs sampled two cycles earlier. It therefore checks only once two cycles have passed since reset.

// File: rtl/ovl_blend.sv
module ovl_blend #(
  parameter int CW       = 8,
  parameter int SELW     = 3,
  parameter int CHAN_IDX = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_en,
  input  logic [SELW-1:0]   ch_sel,
  input  logic              lay_has_alpha,
  input  logic [CW-1:0]     glb_alpha,
  input  logic [31:0]       win_tl,
  input  logic [31:0]       win_br,
  input  logic              in_valid,
  input  logic [15:0]       in_x,
  input  logic [15:0]       in_y,
  input  logic [3*CW-1:0]   in_bg,
  input  logic              lay_valid,
  input  logic [3*CW-1:0]   lay_rgb,
  input  logic [CW-1:0]     lay_alpha,
  output logic              out_valid,
  output logic [3*CW-1:0]   out_rgb
);
  localparam int PW = 2*CW + 2;
  localparam logic [CW-1:0] AMAX = {CW{1'b1}};
  localparam logic [PW-1:0] AMAX_W = PW'(AMAX);
  localparam logic [PW-1:0] HALF = PW'(AMAX >> 1);
  localparam logic [SELW-1:0] MY_SEL = SELW'(CHAN_IDX + 1);

  logic          in_win, hit;
  logic [PW-1:0] mix_prod;
  logic [CW-1:0] mix_a, sel_a;

  assign in_win = (in_x >= win_tl[31:16]) && (in_x <= win_br[31:16]) &&
                  (in_y >= win_tl[15:0])  && (in_y <= win_br[15:0]);
  assign hit    = ch_en && (ch_sel == MY_SEL) && lay_valid && in_win;

  assign mix_prod = PW'(lay_alpha) * PW'(glb_alpha);
  assign mix_a    = CW'((mix_prod + HALF) / AMAX_W);
  assign sel_a    = !lay_has_alpha      ? glb_alpha :
                    (glb_alpha == AMAX) ? lay_alpha : mix_a;

  logic            s1_valid, s1_hit;
  logic [CW-1:0]   s1_a;
  logic [3*CW-1:0] s1_bg, s1_lay;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_a     <= '0;
      s1_bg    <= '0;
      s1_lay   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_hit   <= in_valid && hit;
      s1_a     <= sel_a;
      s1_bg    <= in_bg;
      s1_lay   <= lay_rgb;
    end
  end

  logic [3*CW-1:0] mixed;

  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic [PW-1:0] acc;
    assign acc = PW'(s1_a) * PW'(s1_lay[c*CW +: CW]) +
                 PW'(AMAX - s1_a) * PW'(s1_bg[c*CW +: CW]) + HALF;
    assign mixed[c*CW +: CW] = CW'(acc / AMAX_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_rgb   <= s1_hit ? mixed : s1_bg;
    end
  end
endmodule

// File: rtl/ovl_blend_chk.sv
module ovl_blend_chk #(
  parameter int CW       = 8,
  parameter int SELW     = 3,
  parameter int CHAN_IDX = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ch_en,
  input logic [SELW-1:0]   ch_sel,
  input logic              lay_has_alpha,
  input logic [CW-1:0]     glb_alpha,
  input logic [31:0]       win_tl,
  input logic [31:0]       win_br,
  input logic              in_valid,
  input logic [15:0]       in_x,
  input logic [15:0]       in_y,
  input logic [3*CW-1:0]   in_bg,
  input logic              lay_valid,
  input logic [3*CW-1:0]   lay_rgb,
  input logic [CW-1:0]     lay_alpha,
  input logic              out_valid,
  input logic [3*CW-1:0]   out_rgb
);
  logic [1:0] since_rst;
  logic       ready;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end
  assign ready = (since_rst == 2'd2);

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !out_valid); // R1

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> out_valid == $past(in_valid, 2)); // R2

  AST_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && out_valid && ($past(in_x, 2) > $past(win_br[31:16], 2) ||
                            $past(in_y, 2) > $past(win_br[15:0], 2)))
    |-> out_rgb == $past(in_bg, 2)); // R3

  AST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && out_valid && !$past(ch_en, 2)) |-> out_rgb == $past(in_bg, 2)); // R4

  AST_WRONG_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && out_valid && $past(ch_sel, 2) != SELW'(CHAN_IDX + 1))
    |-> out_rgb == $past(in_bg, 2)); // R5

  AST_NO_LAYER: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && out_valid && !$past(lay_valid, 2)) |-> out_rgb == $past(in_bg, 2)); // R6

  AST_ZERO_ALPHA: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && out_valid && !$past(lay_has_alpha, 2) && $past(glb_alpha, 2) == '0)
    |-> out_rgb == $past(in_bg, 2)); // R7
endmodule

bind ovl_blend ovl_blend_chk #(.CW(CW), .SELW(SELW), .CHAN_IDX(CHAN_IDX)) u_chk (.*);

// File: tb/ovl_blend_tb.sv
`timescale 1ns/1ps
module ovl_blend_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ch_en = 1'b0;
  logic [2:0]  ch_sel = 3'd0;
  logic        lay_has_alpha = 1'b0;
  logic [7:0]  glb_alpha = 8'd0;
  logic [31:0] win_tl = 32'd0, win_br = 32'd0;
  logic        in_valid = 1'b0;
  logic [15:0] in_x = 16'd0, in_y = 16'd0;
  logic [23:0] in_bg = 24'd0;
  logic        lay_valid = 1'b0;
  logic [23:0] lay_rgb = 24'd0;
  logic [7:0]  lay_alpha = 8'd0;
  logic        out_valid;
  logic [23:0] out_rgb;

  int total = 0, bad = 0;
  logic        e1_v = 0, e2_v = 0;
  logic [23:0] e1_rgb = 0, e2_rgb = 0;
  string       e1_tag = "", e2_tag = "";

  always #4 clk = ~clk;

  ovl_blend u_dut (.*);

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int blend(int a, int l, int b);
    return (a * l + (255 - a) * b + 127) / 255;
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic v, int x, int y, logic [23:0] bg,
                      logic lv, logic [23:0] lrgb, logic [7:0] la, string tag);
    logic hit;
    int a;
    logic [23:0] e;
    @(negedge clk);
    check("R2 valid", {23'd0, out_valid}, {23'd0, e2_v});
    if (e2_v) check(e2_tag, out_rgb, e2_rgb);
    e2_v = e1_v; e2_rgb = e1_rgb; e2_tag = e1_tag;
    in_valid = v; in_x = 16'(x); in_y = 16'(y); in_bg = bg;
    lay_valid = lv; lay_rgb = lrgb; lay_alpha = la;
    hit = v && ch_en && ch_sel == 3'd2 && lv &&
          x >= int'(win_tl[31:16]) && x <= int'(win_br[31:16]) &&
          y >= int'(win_tl[15:0]) && y <= int'(win_br[15:0]);
    if (!lay_has_alpha) a = int'(glb_alpha);
    else if (glb_alpha == 8'd255) a = int'(la);
    else a = (int'(la) * int'(glb_alpha) + 127) / 255;
    e = bg;
    if (hit)
      for (int c = 0; c < 3; c++)
        e[c*8 +: 8] = 8'(blend(a, int'(lrgb[c*8 +: 8]), int'(bg[c*8 +: 8])));
    e1_v = v; e1_rgb = e; e1_tag = tag;
  endtask

  task automatic frame(logic holes, string tag);
    for (int y = 0; y < 6; y++)
      for (int x = 0; x < 8; x++) begin
        logic [23:0] bg, lr;
        bg = {8'(x * 30), 8'(y * 40 + 7), 8'(8'h55 ^ 8'(x * y))};
        lr = {8'(200 - x * 9), 8'(x * y * 11), 8'(y * 50)};
        step(1'b1, x, y, bg, !(holes && ((x + y) % 7 == 3)), lr,
             8'((x * 37 + y * 11) % 256), tag);
        if (x == 3) step(1'b0, 0, 0, 24'hFFFFFF, 1'b1, 24'h0, 8'd0, tag);
      end
    step(1'b0, 0, 0, 24'd0, 1'b0, 24'd0, 8'd0, tag);
    step(1'b0, 0, 0, 24'd0, 1'b0, 24'd0, 8'd0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {23'd0, out_valid}, 24'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {23'd0, out_valid}, 24'd0);

    ch_en = 1; ch_sel = 3'd2;
    win_tl = {16'd2, 16'd1}; win_br = {16'd5, 16'd3};
    lay_has_alpha = 0; glb_alpha = 8'd255; frame(0, "R3 R7 opaque window");
    glb_alpha = 8'd0;   frame(0, "R7 zero alpha");
    glb_alpha = 8'd128; frame(0, "R7 R10 global half");
    lay_has_alpha = 1; glb_alpha = 8'd255; frame(0, "R8 R10 pixel alpha");
    glb_alpha = 8'd200; frame(0, "R9 R10 combined");
    glb_alpha = 8'd1;   frame(1, "R6 R9 holes");
    win_tl = {16'd0, 16'd0}; win_br = {16'd7, 16'd5};
    glb_alpha = 8'd90;  frame(0, "R3 full raster");
    win_tl = {16'd4, 16'd2}; win_br = {16'd4, 16'd2};
    lay_has_alpha = 0; glb_alpha = 8'd255; frame(0, "R3 single pixel");
    win_tl = {16'd0, 16'd0}; win_br = {16'd7, 16'd5};
    ch_en = 0; frame(0, "R4 disabled");
    ch_en = 1; ch_sel = 3'd1; frame(0, "R5 wrong select");
    ch_sel = 3'd3; frame(1, "R5 wrong select high");
    ch_sel = 3'd2; frame(1, "R6 R7 back on");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule